// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a serial data line and its forwarded bit clock back into 12-bit parallel words. A fast local clock has already sampled both inputs. The block finds rising edges of the forwarded clock and captures one data bit on each edge. It treats an unusually long high phase of the forwarded clock as the word boundary. Each word takes 14 bit slots: 12 carry data and the stretched high phase uses the rest.

A word goes to the parallel output only when exactly 12 rising edges arrived between two consecutive boundaries. In the same cycle, the word-clock output gives a single low cycle. A word with any other edge count is dropped silently. While the enable is low the receiver is powered down. When the enable returns, the word clock dips low for a fixed short time before it settles high.

Top module: `serial_word_rx`

## Requirements
- R1: During and after reset, `word_o` is 0 and `wclk_o` is 1.
- R2: A data bit is taken from `sdata_i` in the local cycle where `fclk_i` is first seen high after being low. The first bit of a word lands in `word_o[0]` and the twelfth in `word_o[11]`.
- R3: A boundary is the sixth consecutive local sample with `fclk_i` high (1.5 bit periods at 4 samples per bit). When a valid word completes, `word_o` takes the new word and `wclk_o` is low for exactly that one cycle, both right after the boundary sample. `wclk_o` stays high on all other samples of the frame.
- R4: If a boundary is reached after a count of rising edges other than 12 (for example 11 or 13), the word is discarded. `word_o` keeps its value and `wclk_o` stays high. The next correctly framed word is accepted.
- R5: The first boundary after reset or after re-enable only sets alignment. It produces neither a word nor a `wclk_o` pulse.
- R6: Changes on `sdata_i` while `fclk_i` stays high after its rising edge have no effect on the assembled word.
- R7: In the first cycle where `en_i` is sampled high after being low, `wclk_o` goes low. It stays low for exactly 4 local cycles and then returns high.
- R8: While `en_i` is low, the serial inputs are ignored, `wclk_o` is held high, and `word_o` keeps its value.
- R9: A forwarded clock that stays high well beyond the boundary gives only one boundary per high run. No further words or pulses come from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low means power-down |
| sdata_i | input | 1 | Sampled serial data line |
| fclk_i | input | 1 | Sampled forwarded bit clock |
| word_o | output | 12 | Last valid received word |
| wclk_o | output | 1 | Word clock; one low cycle per valid word and a wake-up dip |

## Verification
A rising edge of `fclk_i` registers in the same local cycle it is sampled. `word_o` and the `wclk_o` dip are due just after the sixth high sample of the closing clock pulse. The wake-up dip starts just after the first edge that sees `en_i` high and covers the next four samples. The bench steps the inputs on falling edges and reads the outputs 2 ns after each rising edge. At the boundary sample it checks the exact cycle of the strobe and of the word update. On every other sample of a frame it looks for stray low cycles on `wclk_o`.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
  typedef struct packed {
    logic rise;
    logic bnd;
  } fclk_evt_t;

  function automatic int unsigned bnd_thresh(input int unsigned ovs);
    return (3 * ovs) / 2;
  endfunction
endpackage

// File: rtl/fclk_tracker.sv
module fclk_tracker
  import serial_word_rx_pkg::*;
#(
  parameter int unsigned OVS = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      fclk_i,
  output fclk_evt_t evt_o
);
  localparam int unsigned THRESH = bnd_thresh(OVS);
  localparam int unsigned HW     = $clog2(THRESH + 1);

  logic          fclk_q;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q <= 1'b0;
      hi_cnt <= '0;
    end else begin
      fclk_q <= fclk_i;
      if (clr_i || !fclk_i)              hi_cnt <= '0;
      else if (hi_cnt != HW'(THRESH))    hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // boundary fires once per high run; count saturates afterwards
  always_comb begin
    evt_o.rise = fclk_i && !fclk_q && !clr_i;
    evt_o.bnd  = fclk_i && !clr_i && (hi_cnt == HW'(THRESH - 1));
  end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import serial_word_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned CW    = $clog2(WORD_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  fclk_evt_t         evt_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] shift_o,
  output logic [CW-1:0]     edge_cnt_o,
  output logic              word_ok_o
);
  logic [WORD_W-1:0] sr;
  logic [CW-1:0]     edge_cnt;
  logic              aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr       <= '0;
      edge_cnt <= '0;
      aligned  <= 1'b0;
    end else if (clr_i) begin
      edge_cnt <= '0;
      aligned  <= 1'b0;
    end else begin
      // LSB first: earliest bit ends in bit 0
      if (evt_i.rise) sr <= {sdata_i, sr[WORD_W-1:1]};
      if (evt_i.bnd) begin
        edge_cnt <= '0;
        aligned  <= 1'b1;
      end else if (evt_i.rise && edge_cnt != CW'(WORD_W + 1)) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  assign shift_o    = sr;
  assign edge_cnt_o = edge_cnt;
  assign word_ok_o  = evt_i.bnd && aligned && (edge_cnt == CW'(WORD_W));
endmodule

// File: rtl/wclk_gen.sv
module wclk_gen #(
  parameter int unsigned WAKE_LEN = 4,
  localparam int unsigned WW      = $clog2(WAKE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  output logic wclk_o
);
  logic          en_q;
  logic          strobe_q;
  logic [WW-1:0] wake_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      strobe_q <= 1'b0;
      wake_cnt <= '0;
    end else begin
      en_q     <= en_i;
      strobe_q <= strobe_i && en_i;
      if (!en_i)               wake_cnt <= '0;
      else if (!en_q)          wake_cnt <= WW'(WAKE_LEN);
      else if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
    end
  end

  assign wclk_o = (wake_cnt == '0) && !strobe_q;
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import serial_word_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned OVS      = 4,
  parameter int unsigned WAKE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sdata_i,
  input  logic              fclk_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wclk_o
);
  localparam int unsigned CW = $clog2(WORD_W + 2);

  fclk_evt_t         evt;
  logic [WORD_W-1:0] shift;
  logic [CW-1:0]     edge_cnt;
  logic              word_ok;
  logic [WORD_W-1:0] word_q;
  logic              rx_clr;

  assign rx_clr = !en_i;

  fclk_tracker #(.OVS(OVS)) u_trk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rx_clr),
    .fclk_i(fclk_i),
    .evt_o (evt)
  );

  word_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rx_clr),
    .evt_i     (evt),
    .sdata_i   (sdata_i),
    .shift_o   (shift),
    .edge_cnt_o(edge_cnt),
    .word_ok_o (word_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (word_ok) word_q <= shift;
  end

  wclk_gen #(.WAKE_LEN(WAKE_LEN)) u_wclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .strobe_i(word_ok),
    .wclk_o  (wclk_o)
  );

  assign word_o = word_q;
endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned CW    = $clog2(WORD_W + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              bnd_i,
  input logic [CW-1:0]     edge_cnt_i,
  input logic [WORD_W-1:0] word_o,
  input logic              wclk_o
);
  a_r2_update_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> $past(bnd_i));

  a_r3_update_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> !wclk_o);

  a_r4_bad_count_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && en_i && edge_cnt_i != CW'(WORD_W)) |=> ($stable(word_o) && wclk_o));

  a_r7_wake_dip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> !wclk_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (wclk_o && $stable(word_o)));
endmodule

bind serial_word_rx serial_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .bnd_i     (evt.bnd),
  .edge_cnt_i(edge_cnt),
  .word_o    (word_o),
  .wclk_o    (wclk_o)
);

// File: tb/serial_word_rx_test.sv
`timescale 1ns/1ps
module serial_word_rx_test;
  localparam int HALF   = 2;   // OVS/2 samples per clock phase
  localparam int THRESH = 6;   // boundary sample in a high run
  localparam int HOLD   = 10;  // length of the closing high run

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        sdata_i = 1'b0;
  logic        fclk_i = 1'b0;
  logic [11:0] word_o;
  logic        wclk_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] last_word = '0;

  always #10 clk = ~clk;

  serial_word_rx uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sdata_i(sdata_i),
    .fclk_i (fclk_i),
    .word_o (word_o),
    .wclk_o (wclk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic t_reset();
    #3;
    check(word_o == 12'h000, "R1 word", int'(word_o), 0);
    check(wclk_o == 1'b1, "R1 wclk", int'(wclk_o), 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #2;
    check(word_o == 12'h000 && wclk_o, "R1 after release", int'({wclk_o, word_o}), 'h1000);
  endtask

  task automatic t_powerup();
    @(negedge clk);
    fclk_i = 1'b0;
    en_i   = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      @(posedge clk); #2;
      check(wclk_o == (c > 4), "R7 wake dip", int'(wclk_o), int'(c > 4));
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [11:0] data, input int nedges,
                            input bit exp_valid, input string req);
    int stray = 0;
    logic [11:0] exp_word = exp_valid ? data : last_word;
    for (int b = 0; b < nedges; b++) begin
      logic d = (b < 12) ? data[b] : 1'b0;
      for (int s = 0; s < HALF; s++) begin
        @(negedge clk); fclk_i = 1'b0; sdata_i = d;
        @(posedge clk); #2;
        if (!wclk_o) stray++;
      end
      if (b < nedges - 1) begin
        for (int s = 0; s < HALF; s++) begin
          @(negedge clk); fclk_i = 1'b1; sdata_i = (s == 0) ? d : ~d;  // R6 glitch
          @(posedge clk); #2;
          if (!wclk_o) stray++;
        end
      end else begin
        for (int i = 1; i <= HOLD; i++) begin
          @(negedge clk); fclk_i = 1'b1; sdata_i = (i == 1) ? d : ~d;
          @(posedge clk); #2;
          if (i == THRESH) begin
            check(wclk_o == !exp_valid, {req, " strobe"}, int'(wclk_o), int'(!exp_valid));
            check(word_o == exp_word, {req, " word"}, int'(word_o), int'(exp_word));
          end else if (!wclk_o) stray++;
        end
      end
    end
    check(stray == 0, {req, " stray wclk low (R3)"}, stray, 0);
    last_word = exp_word;
  endtask

  task automatic t_align();
    send_frame(12'h3C3, 12, 1'b0, "R5 align only");
  endtask

  task automatic t_valid_words();
    send_frame(12'hA5C, 12, 1'b1, "R2 R6 word A5C");
    send_frame(12'h001, 12, 1'b1, "R2 lsb first 001");
    send_frame(12'h800, 12, 1'b1, "R2 msb last 800");
    send_frame(12'hFFF, 12, 1'b1, "R3 word FFF");
  endtask

  task automatic t_bad_counts();
    send_frame(12'h123, 11, 1'b0, "R4 eleven edges");
    send_frame(12'h456, 13, 1'b0, "R4 thirteen edges");
    send_frame(12'h789, 12, 1'b1, "R4 recovery");
  endtask

  task automatic t_stall();
    int stray = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); fclk_i = 1'b1; sdata_i = i[0];
      @(posedge clk); #2;
      if (!wclk_o || word_o != last_word) stray++;
    end
    check(stray == 0, "R9 long high run", stray, 0);
    send_frame(12'h5A5, 12, 1'b1, "R9 next word");
  endtask

  task automatic t_disable();
    @(negedge clk); en_i = 1'b0;
    send_frame(12'h0F0, 12, 1'b0, "R8 disabled frame");
    send_frame(12'h00F, 12, 1'b0, "R8 disabled frame 2");
    t_powerup();
    send_frame(12'h111, 12, 1'b0, "R5 realign");
    send_frame(12'hC3A, 12, 1'b1, "R2 after wake");
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_align();
    t_valid_words();
    t_bad_counts();
    t_stall();
    t_disable();
    summary();
    $finish;
  end
endmodule